// File: doc/BRIEF.md
# Message-signalled interrupt file

This block holds the incoming interrupt state for one interrupt file, serving a single privilege level or a single guest. Each interrupt identity from 1 up to `NUM_IDS` has a pending bit and an enable bit. The file also keeps a one-bit delivery switch and a priority threshold. Message-signalled interrupts arrive as an identity number on `msi_id` with a one-cycle `msi_valid` strobe, and each one sets the pending bit of that identity. The block searches continuously for the highest-priority identity that is pending, enabled and not masked by the threshold. It raises `irq_out` whenever delivery is on and such an identity exists.

Software reaches the file through a register port. Each access names a register on `acc_sel` and returns the value the register held before the access, in the same cycle. It applies a masked write of `acc_wdata` under `acc_wmask`, and the write takes effect at the next clock edge. Writing the top-interrupt register claims the current winner by clearing its pending bit. The pending and enable arrays are read and written in 32-bit words. In 64-bit mode an access covers a pair of consecutive words.

`NUM_IDS` must be one less than a multiple of 64, at least 63 and at most 2047.

Top module: `msi_intr_file`

## Requirements
- R1: After a synchronous active-low reset, all pending bits, all enable bits, the delivery bit and the threshold are zero, `irq_out` is low, and every legal register reads as zero.
- R2: Identity 0 is never an interrupt. Bit 0 of pending word 0 and bit 0 of enable word 0 always read 0 and ignore writes. An MSI carrying identity 0 or an identity above `NUM_IDS` changes nothing.
- R3: The top-interrupt register (select 0x02) reads the smallest identity that is pending, enabled and eligible. The identity appears in bits [26:16] and again in bits [10:0], and every other bit reads 0. With no such identity the register reads 0.
- R4: A threshold of 0 masks nothing. A nonzero threshold T makes only identities strictly below T eligible, so a T above `NUM_IDS` also masks nothing.
- R5: An access to select 0x02 with a nonzero `acc_wmask` ignores `acc_wdata` and clears only the pending bit of the identity that was on top in that cycle. It does nothing if no identity was eligible, and an access with an all-zero mask does nothing.
- R6: Select 0x00 is the delivery register, and only its bit 0 is stored. Select 0x01 is the threshold register, and only its bits [10:0] are stored. Both use new = (old & ~mask) | (data & mask).
- R7: `irq_out` is high exactly when the delivery bit is 1 and an eligible identity exists. It follows the state written at the preceding clock edge.
- R8: Select 0x40+n is pending word n and select 0x80+n is enable word n. With `acc_wide`=0, word n covers identities 32n to 32n+31 on `acc_rdata[31:0]` and takes a masked write from `acc_wdata[31:0]`/`acc_wmask[31:0]`.
- R9: With `acc_wide`=1, an even n covers words n (bits [31:0]) and n+1 (bits [63:32]). An odd n, or any n at or beyond (`NUM_IDS`+1)/32, raises `acc_err`, reads 0 and changes nothing.
- R10: An MSI with identity 1..`NUM_IDS` sets that pending bit at the next edge. If an access clears the same bit in the same cycle, the MSI wins and the bit ends up set.
- R11: Every access returns the value the register held before that access, and the write becomes visible from the next cycle.
- R12: Selects 0x03..0x3F and 0xC0..0xFF are illegal. They raise `acc_err` in the same cycle, read 0 and change nothing. With `acc_valid` low, `acc_rdata` and `acc_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | An incoming message is present this cycle |
| msi_id | input | 11 | Identity carried by the message |
| acc_valid | input | 1 | Register access this cycle |
| acc_sel | input | 8 | Register select |
| acc_wide | input | 1 | 64-bit word mode for pending/enable words |
| acc_wdata | input | 64 | Write data |
| acc_wmask | input | 64 | Write bit mask |
| acc_rdata | output | 64 | Old value of the selected register |
| acc_err | output | 1 | Access was illegal |
| irq_out | output | 1 | External interrupt request |

## Verification
`acc_rdata` and `acc_err` are combinational, so they are due in the cycle of the access itself. The bench drives each access on a falling edge and samples these two outputs 2 ns later, before the rising edge. Register updates, pending bits set by MSIs and `irq_out` change after the rising edge that ends the access. The bench updates its model at that edge and checks `irq_out` 1 ns after it. Read-back of written state is checked by a later access, which also confirms that the old value is returned in the cycle of the write.

// File: rtl/msi_intr_file_pkg.sv
// Shared constants and types for the interrupt file.
// Assumes identity numbers fit in ID_W bits (up to 2047).
package msi_intr_file_pkg;
    localparam int ID_W    = 11;
    localparam int WORD_W  = 32;
    localparam int SEL_W   = 8;
    localparam int DATA_W  = 64;
    localparam int TOP_ID_LSB = 16;

    typedef enum logic [1:0] {
        GRP_CTRL = 2'd0,
        GRP_PEND = 2'd1,
        GRP_EN   = 2'd2,
        GRP_NONE = 2'd3
    } sel_grp_e;

    localparam logic [5:0] CTRL_DELIV = 6'd0;
    localparam logic [5:0] CTRL_THR   = 6'd1;
    localparam logic [5:0] CTRL_TOP   = 6'd2;
endpackage

// File: rtl/msi_lowest_first.sv
// Priority encoder: returns the lowest set index above 0, or 0 when none.
// Assumes bit 0 of the request is not a valid source.
module msi_lowest_first #(
    parameter int W     = 64,
    parameter int IDX_W = 11
) (
    input  logic [W-1:0]     req,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the smallest index is the last to win.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 1; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/msi_word_access.sv
// Word port onto a bit array: decodes a word index in 32- or 64-bit mode,
// returns the selected bits and spreads a masked write over the array.
// Assumes TOT is a multiple of 64, so a legal even index always has a partner.
module msi_word_access #(
    parameter int TOT = 64
) (
    input  logic           wide,
    input  logic [5:0]     idx,
    input  logic [63:0]    wdata,
    input  logic [63:0]    wmask,
    input  logic [TOT-1:0] state,
    output logic           legal,
    output logic [63:0]    rd,
    output logic [TOT-1:0] bmask,
    output logic [TOT-1:0] bdata
);
    localparam int NW = TOT / 32;

    // Legality, read selection and write spreading per 32-bit word.
    always_comb begin
        legal = wide ? (!idx[0] && (int'(idx) < NW)) : (int'(idx) < NW);
        rd    = '0;
        bmask = '0;
        bdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (!wide && int'(idx) == w) begin
                rd[31:0]         = state[w*32 +: 32];
                bmask[w*32 +: 32] = wmask[31:0];
                bdata[w*32 +: 32] = wdata[31:0];
            end
            if (wide && !idx[0] && int'(idx) == w) begin
                rd[31:0]         = state[w*32 +: 32];
                bmask[w*32 +: 32] = wmask[31:0];
                bdata[w*32 +: 32] = wdata[31:0];
            end
            if (wide && !idx[0] && int'(idx) + 1 == w) begin
                rd[63:32]        = state[w*32 +: 32];
                bmask[w*32 +: 32] = wmask[63:32];
                bdata[w*32 +: 32] = wdata[63:32];
            end
        end
    end
endmodule

// File: rtl/msi_intr_file.sv
// Interrupt file: pending/enable arrays, delivery bit, threshold, lowest-
// identity-first search, claim on top-register write, one interrupt output.
// Assumes NUM_IDS + 1 is a multiple of 64 and NUM_IDS <= 2047.
module msi_intr_file
    import msi_intr_file_pkg::*;
#(
    parameter int NUM_IDS = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    input  logic [ID_W-1:0]   msi_id,
    input  logic              acc_valid,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic              acc_wide,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] acc_wmask,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err,
    output logic              irq_out
);
    localparam int TOT = NUM_IDS + 1;

    logic [TOT-1:0]  pend_q, en_q, pend_n, en_n;
    logic            deliv_q, deliv_n;
    logic [ID_W-1:0] thr_q, thr_n;
    logic [TOT-1:0]  below, clr_vec, set_vec, eligible;
    logic [ID_W-1:0] top_id;
    logic            top_hit;

    sel_grp_e        grp;
    logic [5:0]      sub;
    logic            p_legal, e_legal, legal, claim;
    logic [63:0]     p_rd, e_rd;
    logic [TOT-1:0]  p_bmask, p_bdata, e_bmask, e_bdata;

    assign grp = sel_grp_e'(acc_sel[7:6]);
    assign sub = acc_sel[5:0];

    // Per-identity threshold mask, claim decode and MSI decode.
    for (genvar i = 0; i < TOT; i++) begin : g_id
        assign below[i]   = (thr_q == '0) || (ID_W'(i) < thr_q);
        assign clr_vec[i] = (top_id == ID_W'(i));
        if (i == 0) begin : g_zero
            assign set_vec[i] = 1'b0;
        end else begin : g_rest
            assign set_vec[i] = msi_valid && (msi_id == ID_W'(i));
        end
    end

    assign eligible = pend_q & en_q & below;

    msi_lowest_first #(.W(TOT), .IDX_W(ID_W)) u_prio (
        .req (eligible),
        .idx (top_id)
    );

    assign top_hit = (top_id != '0);
    assign irq_out = deliv_q && top_hit;

    msi_word_access #(.TOT(TOT)) u_pend_port (
        .wide (acc_wide), .idx (sub), .wdata (acc_wdata), .wmask (acc_wmask),
        .state (pend_q), .legal (p_legal), .rd (p_rd),
        .bmask (p_bmask), .bdata (p_bdata)
    );

    msi_word_access #(.TOT(TOT)) u_en_port (
        .wide (acc_wide), .idx (sub), .wdata (acc_wdata), .wmask (acc_wmask),
        .state (en_q), .legal (e_legal), .rd (e_rd),
        .bmask (e_bmask), .bdata (e_bdata)
    );

    // Select legality for the current access.
    always_comb begin
        unique case (grp)
            GRP_CTRL: legal = (sub == CTRL_DELIV) || (sub == CTRL_THR) || (sub == CTRL_TOP);
            GRP_PEND: legal = p_legal;
            GRP_EN:   legal = e_legal;
            default:  legal = 1'b0;
        endcase
    end

    assign acc_err = acc_valid && !legal;
    assign claim   = acc_valid && grp == GRP_CTRL && sub == CTRL_TOP
                     && (acc_wmask != '0) && top_hit;

    // Read mux returning the pre-access value of the selected register.
    always_comb begin
        acc_rdata = '0;
        if (acc_valid && legal) begin
            unique case (grp)
                GRP_CTRL: begin
                    if (sub == CTRL_DELIV) acc_rdata[0] = deliv_q;
                    else if (sub == CTRL_THR) acc_rdata[ID_W-1:0] = thr_q;
                    else begin
                        acc_rdata[TOP_ID_LSB +: ID_W] = top_id;
                        acc_rdata[ID_W-1:0]           = top_id;
                    end
                end
                GRP_PEND: acc_rdata = p_rd;
                GRP_EN:   acc_rdata = e_rd;
                default:  acc_rdata = '0;
            endcase
        end
    end

    // Next-state: masked writes, then claim, then MSI set; bit 0 held at 0.
    always_comb begin
        deliv_n = deliv_q;
        thr_n   = thr_q;
        pend_n  = pend_q;
        en_n    = en_q;
        if (acc_valid && legal) begin
            if (grp == GRP_CTRL && sub == CTRL_DELIV)
                deliv_n = (deliv_q & ~acc_wmask[0]) | (acc_wdata[0] & acc_wmask[0]);
            if (grp == GRP_CTRL && sub == CTRL_THR)
                thr_n = (thr_q & ~acc_wmask[ID_W-1:0]) | (acc_wdata[ID_W-1:0] & acc_wmask[ID_W-1:0]);
            if (grp == GRP_PEND)
                pend_n = (pend_q & ~p_bmask) | (p_bdata & p_bmask);
            if (grp == GRP_EN)
                en_n = (en_q & ~e_bmask) | (e_bdata & e_bmask);
        end
        if (claim) pend_n = pend_n & ~clr_vec;
        pend_n    = pend_n | set_vec;
        pend_n[0] = 1'b0;
        en_n[0]   = 1'b0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            en_q    <= '0;
            deliv_q <= 1'b0;
            thr_q   <= '0;
        end else begin
            pend_q  <= pend_n;
            en_q    <= en_n;
            deliv_q <= deliv_n;
            thr_q   <= thr_n;
        end
    end
endmodule

// File: rtl/msi_intr_file_chk.sv
// Assertion checker for the interrupt file, attached by bind below.
// Assumes visibility of the state arrays and the search result.
module msi_intr_file_chk
    import msi_intr_file_pkg::*;
#(
    parameter int NUM_IDS = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msi_valid,
    input logic [ID_W-1:0]   msi_id,
    input logic              acc_valid,
    input logic [SEL_W-1:0]  acc_sel,
    input logic [DATA_W-1:0] acc_wmask,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              acc_err,
    input logic              irq_out,
    input logic [NUM_IDS:0]  pend,
    input logic [NUM_IDS:0]  en,
    input logic [ID_W-1:0]   thr,
    input logic [ID_W-1:0]   top_id
);
    localparam int TOT = NUM_IDS + 1;

    logic [TOT-1:0] top_1h, msi_1h;
    logic           msi_in_range, claim_req;

    // One-hot forms of the winner and the arriving identity.
    assign top_1h       = TOT'(1) << top_id;
    assign msi_1h       = TOT'(1) << msi_id;
    assign msi_in_range = msi_valid && (msi_id != '0) && (int'(msi_id) <= NUM_IDS);
    assign claim_req    = acc_valid && (acc_sel == 8'h02) && (acc_wmask != '0);

    // R3: nothing pending and enabled lies below the winner.
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (top_id != '0) |-> ((pend & en & (top_1h - TOT'(1))) == '0));

    // R4: a nonzero threshold keeps the winner strictly below it.
    a_r4_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (top_id != '0 && thr != '0) |-> (top_id < thr));

    // R7: a raised output always has a pending and enabled source.
    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((pend & en & top_1h) != '0));

    // R5: a claim clears the claimed pending bit unless an MSI arrives.
    a_r5_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_req && top_id != '0 && !msi_valid) |=> ((pend & $past(top_1h)) == '0));

    // R10: an in-range MSI sets its pending bit.
    a_r10_msi_sets: assert property (@(posedge clk) disable iff (!rst_n)
        msi_in_range |=> ((pend & $past(msi_1h)) != '0));

    // R12: an illegal access reads as zero.
    a_r12_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_rdata == '0));
endmodule

bind msi_intr_file msi_intr_file_chk #(.NUM_IDS(NUM_IDS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_valid (msi_valid),
    .msi_id    (msi_id),
    .acc_valid (acc_valid),
    .acc_sel   (acc_sel),
    .acc_wmask (acc_wmask),
    .acc_rdata (acc_rdata),
    .acc_err   (acc_err),
    .irq_out   (irq_out),
    .pend      (pend_q),
    .en        (en_q),
    .thr       (thr_q),
    .top_id    (top_id)
);

// File: tb/msi_intr_file_tb_top.sv
// Self-checking bench: directed corners plus seeded random traffic against a
// behavioural model built from the requirements.
module msi_intr_file_tb_top;
    localparam int NUM_IDS = 63;
    localparam int TOT = NUM_IDS + 1;
    localparam int NW = TOT / 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [10:0] msi_id = '0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_sel = '0;
    logic        acc_wide = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_wmask = '0;
    logic [63:0] acc_rdata;
    logic        acc_err;
    logic        irq_out;

    int checks = 0;
    int fails = 0;

    logic [TOT-1:0] mp = '0, me = '0;
    logic           md = 1'b0;
    logic [10:0]    mt = '0;

    always #5 clk = ~clk;

    msi_intr_file #(.NUM_IDS(NUM_IDS)) dut_i (
        .clk (clk), .rst_n (rst_n), .msi_valid (msi_valid), .msi_id (msi_id),
        .acc_valid (acc_valid), .acc_sel (acc_sel), .acc_wide (acc_wide),
        .acc_wdata (acc_wdata), .acc_wmask (acc_wmask), .acc_rdata (acc_rdata),
        .acc_err (acc_err), .irq_out (irq_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] ref_top();
        for (int i = 1; i < TOT; i++)
            if (mp[i] && me[i] && (mt == 0 || i < int'(mt))) return 11'(i);
        return '0;
    endfunction

    function automatic void ref_read(input logic av, input logic [7:0] sel, input logic wide,
                                     output logic ok, output logic [63:0] rd);
        int n = int'(sel[5:0]);
        logic [TOT-1:0] v;
        logic [10:0] t;
        ok = 1'b0;
        rd = '0;
        if (!av) return;
        case (sel[7:6])
            2'd0: begin
                if (n == 0) begin ok = 1; rd = {63'd0, md}; end
                else if (n == 1) begin ok = 1; rd = {53'd0, mt}; end
                else if (n == 2) begin ok = 1; t = ref_top(); rd = {37'd0, t, 5'd0, t}; end
            end
            2'd1, 2'd2: begin
                v = (sel[7:6] == 2'd1) ? mp : me;
                if (!wide && n < NW) begin ok = 1; rd = {32'd0, v[n*32 +: 32]}; end
                if (wide && (n % 2 == 0) && n < NW) begin
                    ok = 1; rd = {v[n*32+32 +: 32], v[n*32 +: 32]};
                end
            end
            default: ok = 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] sel, input logic wide, input logic ok);
        if (!ok) return wide ? "R9" : "R12";
        if (sel[7:6] == 2'd0) return (sel[5:0] == 6'd2) ? "R3" : "R6";
        return wide ? "R9" : "R8";
    endfunction

    // One cycle: drive, check same-cycle read, update model at the edge, check irq.
    task automatic op(input logic av, input logic [7:0] sel, input logic wide,
                      input logic [63:0] wd, input logic [63:0] wm,
                      input logic mv, input logic [10:0] mi, input string tag);
        logic ok;
        logic [63:0] exp;
        logic [10:0] t;
        int n;
        string tg;
        @(negedge clk);
        acc_valid = av; acc_sel = sel; acc_wide = wide; acc_wdata = wd; acc_wmask = wm;
        msi_valid = mv; msi_id = mi;
        #2;
        ref_read(av, sel, wide, ok, exp);
        tg = (tag == "") ? tag_of(sel, wide, ok) : tag;
        chk({tg, " rdata (R11 old value)"}, acc_rdata, exp);
        chk({tg, " err"}, {63'd0, acc_err}, {63'd0, av && !ok});
        t = ref_top();
        n = int'(sel[5:0]);
        @(posedge clk);
        #1;
        if (av && ok) begin
            case (sel[7:6])
                2'd0: begin
                    if (n == 0 && wm[0]) md = wd[0];
                    if (n == 1) mt = (mt & ~wm[10:0]) | (wd[10:0] & wm[10:0]);
                    if (n == 2 && wm != 0 && t != 0) mp[t] = 1'b0;
                end
                2'd1: for (int b = 0; b < (wide ? 64 : 32); b++) if (wm[b]) mp[n*32+b] = wd[b];
                2'd2: for (int b = 0; b < (wide ? 64 : 32); b++) if (wm[b]) me[n*32+b] = wd[b];
                default: ;
            endcase
        end
        if (mv && mi != 0 && int'(mi) < TOT) mp[mi] = 1'b1;
        mp[0] = 1'b0;
        me[0] = 1'b0;
        acc_valid = 1'b0; msi_valid = 1'b0;
        chk("R7 irq", {63'd0, irq_out}, {63'd0, md && (ref_top() != 0)});
    endtask

    task automatic rd(input logic [7:0] sel, input logic wide, input string tag);
        op(1'b1, sel, wide, '0, '0, 1'b0, '0, tag);
    endtask

    task automatic wr(input logic [7:0] sel, input logic wide, input logic [63:0] wd,
                      input logic [63:0] wm, input string tag);
        op(1'b1, sel, wide, wd, wm, 1'b0, '0, tag);
    endtask

    task automatic msi(input logic [10:0] id, input string tag);
        op(1'b0, 8'h00, 1'b0, '0, '0, 1'b1, id, tag);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s;
        void'($urandom(32'd4983));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq in reset", {63'd0, irq_out}, 64'd0);
        rst_n = 1'b1;
        // R1: reset state reads zero everywhere
        rd(8'h00, 0, "R1"); rd(8'h01, 0, "R1"); rd(8'h02, 0, "R1");
        rd(8'h40, 1, "R1"); rd(8'h80, 1, "R1");
        // R2: bit 0 of word 0 is stuck at zero
        wr(8'h40, 0, '1, '1, "R2"); wr(8'h80, 0, '1, '1, "R2");
        rd(8'h40, 0, "R2"); rd(8'h80, 0, "R2");
        wr(8'h40, 1, '0, '1, "R2"); wr(8'h80, 1, '0, '1, "R2");
        msi(11'd0, "R2"); msi(11'd64, "R2"); msi(11'd2047, "R2");
        rd(8'h40, 1, "R2");
        // R10: MSI sets pending; R3 lowest wins
        msi(11'd40, "R10"); msi(11'd9, "R10"); msi(11'd5, "R10");
        rd(8'h40, 1, "R10");
        wr(8'h80, 1, '1, '1, "R8");
        rd(8'h02, 0, "R3");
        wr(8'h00, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R11");
        rd(8'h00, 0, "R6");
        // R4: threshold boundaries
        wr(8'h01, 0, 64'd5, '1, "R4"); rd(8'h02, 0, "R4");
        wr(8'h01, 0, 64'd6, '1, "R4"); rd(8'h02, 0, "R4");
        wr(8'h01, 0, 64'd100, '1, "R4"); rd(8'h02, 0, "R4");
        wr(8'h01, 0, 64'hFFFF, '1, "R6"); rd(8'h01, 0, "R6");
        wr(8'h01, 0, 64'd0, '1, "R4"); rd(8'h02, 0, "R4");
        // R5: claim ignores data, needs nonzero mask
        wr(8'h02, 0, '0, '0, "R5"); rd(8'h02, 0, "R5");
        wr(8'h02, 0, 64'h1234, 64'h8, "R5"); rd(8'h02, 0, "R5");
        // R10: MSI beats same-cycle claim of the same identity
        op(1'b1, 8'h02, 0, '0, '1, 1'b1, 11'd9, "R10");
        rd(8'h02, 0, "R10");
        // R9/R12: illegal selects
        rd(8'h41, 1, "R9"); rd(8'h42, 0, "R9"); rd(8'h42, 1, "R9");
        wr(8'h03, 0, '1, '1, "R12"); wr(8'hC5, 0, '1, '1, "R12");
        op(1'b0, 8'h40, 0, '1, '1, 1'b0, '0, "R12");
        rd(8'h40, 1, "R12");
        // Random traffic
        for (int k = 0; k < 2000; k++) begin
            int r = $urandom_range(0, 9);
            logic [63:0] d, m;
            d = {$urandom, $urandom};
            case ($urandom_range(0, 2))
                0: m = '1;
                1: m = '0;
                default: m = {$urandom, $urandom};
            endcase
            if (r < 4) s = {($urandom_range(0, 1) == 0) ? 2'd1 : 2'd2, 4'd0, 2'($urandom_range(0, 3))};
            else if (r < 8) s = {6'd0, 2'($urandom_range(0, 3))};
            else s = 8'($urandom_range(0, 255));
            if (s == 8'h01) d = 64'($urandom_range(0, 80));
            op($urandom_range(0, 4) != 0, s, 1'($urandom_range(0, 1)), d, m,
               $urandom_range(0, 1) == 1, 11'($urandom_range(0, 70)), "");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule